// File: doc/BRIEF.md
# NAND ECC Page Status Aggregator

This block sits beside a NAND page-read datapath and turns the per-sector status words left behind by an ECC engine into page-level results. A page is made of up to 63 sectors of 512 or 1024 bytes. After each sector is decoded, the engine writes one 64-bit status word per sector into a small RAM. This block reads that RAM through a simple one-cycle-latency read port.

A start pulse carries the number of sectors in the page. The block first polls the status word of the final sector until its completion flag appears. It then walks the sectors from first to last, one RAM read every other cycle. Along the way it keeps the largest per-sector corrected count and the running sum of all counts. It also streams out the two spare user bytes of each sector, one byte per cycle. A sector whose count field carries the reserved uncorrectable code ends the walk and raises a failure flag. If the completion flag never appears, a parameterised cycle limit ends the wait with a timeout flag.

Top module: `ecc_page_scan`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, timeout_o, ub_valid_o and rd_en_o are 0, and max_flips_o and sum_flips_o are 0.
- R2: A start with N ≥ 1 sectors first reads RAM address N-1 and reads no other address until that word has bit 31 set. While bit 31 stays clear, the read repeats once every POLL_GAP (16) cycles.
- R3: Once bit 31 of word N-1 is seen set, the block reads addresses 0 to N-1 in increasing order. Bit 31 of the other words has no effect. Bits 63:32, bit 30 and bits 23:16 (which include the zero-bit count) do not affect any result.
- R4: max_flips_o equals the largest value of bits 29:24 over the sectors that were accepted.
- R5: sum_flips_o equals the sum of bits 29:24 over the sectors that were accepted.
- R6: A sector whose bits 29:24 equal 0x3F sets fail_o and ends the scan. That sector adds nothing to the results and emits no bytes, and no later sector is read.
- R7: Each accepted sector emits bits 7:0 and then bits 15:8 on ub_byte_o, each with ub_valid_o high for one cycle. The bytes follow sector order.
- R8: If bit 31 is not seen within TIMEOUT_CYC polling cycles, done_o and timeout_o go high TIMEOUT_CYC cycles after the start edge, with both counts at 0.
- R9: done_o is high for exactly one cycle. max_flips_o, sum_flips_o, fail_o and timeout_o hold their values until the next accepted start, which clears them.
- R10: A start while busy_o is high is ignored and does not change the run in progress or its results.
- R11: A start with N = 0 gives done_o in the next cycle, issues no read and returns zero results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| nsect_i | input | AW (6) | Number of sectors in the page |
| rd_en_o | output | 1 | Status RAM read enable |
| rd_addr_o | output | AW (6) | Status RAM read address |
| rd_data_i | input | 64 | Status word, valid one cycle after rd_en_o |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | An uncorrectable sector was found |
| timeout_o | output | 1 | Completion flag never seen |
| max_flips_o | output | 6 | Largest per-sector corrected count |
| sum_flips_o | output | AW+6 (12) | Total corrected count |
| ub_valid_o | output | 1 | User byte valid |
| ub_byte_o | output | 8 | User byte stream |

## Verification
Pages are built with different corrected counts in odd and even sectors, so max and sum are told apart and an order error shows up. The full 63-sector page checks the width of the sum. Failures are placed at the first and at a middle sector to separate "stop and exclude" from "count and continue". All status words carry junk in the ignored fields, and completion flags are set on every word except the last, so that decoding the wrong word is visible. Separate runs withhold the final flag, either for good (timeout and poll spacing) or for about 40 cycles (late completion). Further runs cover a zero-sector start and a start during a busy run.

// File: rtl/ecc_page_scan.sv
module ecc_page_scan #(
  parameter int MAX_SECT    = 63,
  parameter int POLL_GAP    = 16,
  parameter int TIMEOUT_CYC = 4096,
  localparam int AW    = $clog2(MAX_SECT + 1),
  localparam int SUM_W = AW + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    nsect_i,
  output logic             rd_en_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [63:0]      rd_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             timeout_o,
  output logic [5:0]       max_flips_o,
  output logic [SUM_W-1:0] sum_flips_o,
  output logic             ub_valid_o,
  output logic [7:0]       ub_byte_o
);
  localparam int GW = (POLL_GAP > 2) ? $clog2(POLL_GAP) : 1;
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_POLL, S_SCAN, S_TAIL} st_t;

  st_t           st;
  logic [AW-1:0] last, idx;
  logic          ph, rvld, hi_pend;
  logic [7:0]    hi;
  logic [GW-1:0] gcnt;
  logic [TW-1:0] tcnt;

  wire [5:0] err  = rd_data_i[29:24];
  wire       bad  = (err == 6'h3F);
  wire       seen = (st == S_POLL) && rvld && rd_data_i[31];
  wire       unused_fields = ^{rd_data_i[63:32], rd_data_i[30], rd_data_i[23:16]};

  assign rd_en_o   = ((st == S_POLL) && (gcnt == '0)) || ((st == S_SCAN) && !ph);
  assign rd_addr_o = (st == S_POLL) ? last : idx;
  assign busy_o    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; last <= '0; idx <= '0; ph <= 1'b0; rvld <= 1'b0;
      hi_pend <= 1'b0; hi <= '0; gcnt <= '0; tcnt <= '0;
      done_o <= 1'b0; fail_o <= 1'b0; timeout_o <= 1'b0;
      max_flips_o <= '0; sum_flips_o <= '0;
      ub_valid_o <= 1'b0; ub_byte_o <= '0;
    end else begin
      done_o     <= 1'b0;
      ub_valid_o <= 1'b0;
      rvld       <= rd_en_o;
      case (st)
        S_IDLE: if (start_i) begin
          fail_o <= 1'b0; timeout_o <= 1'b0;
          max_flips_o <= '0; sum_flips_o <= '0;
          hi_pend <= 1'b0;
          if (nsect_i == '0) begin
            done_o <= 1'b1;
          end else begin
            last <= nsect_i - 1'b1;
            gcnt <= '0;
            tcnt <= '0;
            st   <= S_POLL;
          end
        end
        S_POLL: begin
          if (seen) begin
            idx <= '0;
            ph  <= 1'b0;
            st  <= S_SCAN;
          end else if (tcnt == TW'(TIMEOUT_CYC - 1)) begin
            timeout_o <= 1'b1;
            done_o    <= 1'b1;
            st        <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
            gcnt <= (gcnt == '0) ? GW'(POLL_GAP - 1) : gcnt - 1'b1;
          end
        end
        S_SCAN: begin
          if (!ph) begin
            ph <= 1'b1;
            if (hi_pend) begin
              ub_valid_o <= 1'b1;
              ub_byte_o  <= hi;
              hi_pend    <= 1'b0;
            end
          end else if (bad) begin
            fail_o <= 1'b1;
            done_o <= 1'b1;
            st     <= S_IDLE;
          end else begin
            if (err > max_flips_o) max_flips_o <= err;
            sum_flips_o <= sum_flips_o + SUM_W'(err);
            ub_valid_o  <= 1'b1;
            ub_byte_o   <= rd_data_i[7:0];
            hi          <= rd_data_i[15:8];
            hi_pend     <= 1'b1;
            ph          <= 1'b0;
            if (idx == last) st <= S_TAIL;
            else idx <= idx + 1'b1;
          end
        end
        S_TAIL: begin
          ub_valid_o <= 1'b1;
          ub_byte_o  <= hi;
          hi_pend    <= 1'b0;
          done_o     <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecc_page_scan_chk.sv
module ecc_page_scan_chk #(
  parameter int AW    = 6,
  parameter int SUM_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [AW-1:0]    nsect_i,
  input logic             rd_en_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             fail_o,
  input logic             timeout_o,
  input logic [5:0]       max_flips_o,
  input logic [SUM_W-1:0] sum_flips_o,
  input logic             ub_valid_o
);
  // R1
  reads_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> busy_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(max_flips_o) && $stable(sum_flips_o) && $stable(fail_o) && $stable(timeout_o)));

  // R6
  fail_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> !busy_o);

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail_o && timeout_o));

  // R4
  max_not_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    max_flips_o != 6'h3F);

  // R11
  empty_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && nsect_i == '0) |=> (done_o && !busy_o));

  // R7
  bytes_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ub_valid_o |-> (busy_o || done_o));
endmodule

bind ecc_page_scan ecc_page_scan_chk #(.AW(AW), .SUM_W(SUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .nsect_i(nsect_i),
  .rd_en_o(rd_en_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
  .timeout_o(timeout_o), .max_flips_o(max_flips_o), .sum_flips_o(sum_flips_o),
  .ub_valid_o(ub_valid_o)
);

// File: tb/ecc_page_scan_bench.sv
module ecc_page_scan_bench;
  localparam int TMO = 200;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [5:0]  nsect = 0;
  logic        rd_en;
  logic [5:0]  rd_addr;
  logic [63:0] rdata = '0;
  logic        busy, done, fail, tmo, ubv;
  logic [5:0]  maxf;
  logic [11:0] sumf;
  logic [7:0]  ubb;

  always #10 clk = ~clk;

  ecc_page_scan #(.TIMEOUT_CYC(TMO)) u_ecc_page_scan (
    .clk(clk), .rst_n(rst_n), .start_i(start), .nsect_i(nsect),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rdata),
    .busy_o(busy), .done_o(done), .fail_o(fail), .timeout_o(tmo),
    .max_flips_o(maxf), .sum_flips_o(sumf), .ub_valid_o(ubv), .ub_byte_o(ubb)
  );

  logic [63:0] mem [0:63];
  always @(posedge clk) if (rd_en) rdata <= mem[rd_addr];

  int cyc = 0, rcnt = 0, ngot = 0, dcnt = 0;
  logic [5:0] rlog_a [0:1023];
  int         rlog_c [0:1023];
  logic [7:0] got [0:1023];
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) begin
      rlog_a[rcnt % 1024] <= rd_addr;
      rlog_c[rcnt % 1024] <= cyc;
      rcnt <= rcnt + 1;
    end
    if (ubv) begin
      got[ngot % 1024] <= ubb;
      ngot <= ngot + 1;
    end
    if (done) dcnt <= dcnt + 1;
  end

  int nchk = 0, nfail = 0;
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [6:0]  n;
    logic [5:0]  e_odd;
    logic [5:0]  e_even;
    logic [6:0]  fat;
    logic [5:0]  xmax;
    logic [11:0] xsum;
    logic        xfail;
  } vec_t;

  localparam vec_t VEC [0:4] = '{
    '{7'd1,  6'd0,  6'd5, 7'd127, 6'd5,  12'd5,    1'b0},
    '{7'd4,  6'd3,  6'd1, 7'd127, 6'd3,  12'd8,    1'b0},
    '{7'd63, 6'd62, 6'd0, 7'd127, 6'd62, 12'd1922, 1'b0},
    '{7'd5,  6'd2,  6'd7, 7'd3,   6'd7,  12'd16,   1'b1},
    '{7'd3,  6'd1,  6'd1, 7'd0,   6'd0,  12'd0,    1'b1}
  };

  function automatic logic [7:0] lo_b(input int i); return 8'(8'h10 + i); endfunction
  function automatic logic [7:0] hi_b(input int i); return 8'(8'hA0 ^ i); endfunction

  task automatic fill(input int n, input int eo, input int ee, input int fat, input bit cmpl);
    for (int i = 0; i < 64; i++) begin
      logic [5:0] e;
      e = (i == fat) ? 6'h3F : ((i % 2 == 1) ? 6'(eo) : 6'(ee));
      mem[i] = {32'hDEADBEEF, (i == n - 1) ? cmpl : 1'b1, 1'b1, e, 2'b11, 6'h2A, hi_b(i), lo_b(i)};
    end
  endtask

  int rbase, bbase, dbase;
  task automatic kick(input int n);
    @(negedge clk);
    #1;
    rbase = rcnt; bbase = ngot; dbase = dcnt;
    start = 1; nsect = 6'(n);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < 5000) begin
      @(negedge clk);
      k++;
    end
    #1;
  endtask

  initial begin
    int k;
    bit ok;
    fill(1, 0, 0, 127, 1);
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !fail && !tmo && !ubv && !rd_en && maxf == 0 && sumf == 0,
          "R1 reset state", {busy, done, fail, tmo, ubv, rd_en}, 0);
    rst_n = 1;

    for (int v = 0; v < 5; v++) begin
      int n, nacc;
      n = int'(VEC[v].n);
      nacc = VEC[v].xfail ? int'(VEC[v].fat) : n;
      fill(n, VEC[v].e_odd, VEC[v].e_even, VEC[v].fat, 1);
      kick(n);
      wait_done(k);
      check(maxf == VEC[v].xmax, "R4 max flips", maxf, VEC[v].xmax);
      check(sumf == VEC[v].xsum, "R5 sum flips", sumf, VEC[v].xsum);
      check(fail == VEC[v].xfail && !tmo, "R6 fail flag", fail, VEC[v].xfail);
      check(rcnt - rbase == 1 + (VEC[v].xfail ? nacc + 1 : n), "R3 R6 read count",
            rcnt - rbase, 1 + (VEC[v].xfail ? nacc + 1 : n));
      ok = (rlog_a[rbase % 1024] == 6'(n - 1));
      for (int j = 1; j < rcnt - rbase; j++)
        if (rlog_a[(rbase + j) % 1024] != 6'(j - 1)) ok = 0;
      check(ok, "R2 R3 read order", rlog_a[rbase % 1024], n - 1);
      check(ngot - bbase == 2 * nacc, "R7 byte count", ngot - bbase, 2 * nacc);
      ok = 1;
      for (int j = 0; j < 2 * nacc && j < ngot - bbase; j++)
        if (got[(bbase + j) % 1024] != ((j % 2 == 0) ? lo_b(j / 2) : hi_b(j / 2))) ok = 0;
      check(ok, "R7 byte order", got[bbase % 1024], lo_b(0));
      @(negedge clk);
      check(!done, "R9 done one cycle", done, 0);
    end

    // R9 hold
    begin
      logic [5:0] m0; logic [11:0] s0; logic f0;
      m0 = maxf; s0 = sumf; f0 = fail;
      repeat (10) @(negedge clk);
      check(maxf == m0 && sumf == s0 && fail == f0, "R9 results hold", sumf, s0);
    end

    // R11
    kick(0);
    check(done && maxf == 0 && sumf == 0 && !fail, "R11 empty page done", done, 1);
    #1;
    check(rcnt == rbase, "R11 no reads", rcnt - rbase, 0);

    // R8 and R2 poll spacing
    fill(4, 1, 1, 127, 0);
    kick(4);
    wait_done(k);
    check(k == TMO && tmo && !fail, "R8 timeout cycle", k, TMO);
    check(maxf == 0 && sumf == 0 && ngot == bbase, "R8 zero results", sumf, 0);
    check(rcnt - rbase == 13, "R2 poll read count", rcnt - rbase, 13);
    ok = 1;
    for (int j = 0; j < rcnt - rbase; j++) begin
      if (rlog_a[(rbase + j) % 1024] != 6'd3) ok = 0;
      if (j > 0 && rlog_c[(rbase + j) % 1024] - rlog_c[(rbase + j - 1) % 1024] != 16) ok = 0;
    end
    check(ok, "R2 poll address and spacing", rlog_a[rbase % 1024], 3);

    // R2 late completion
    fill(2, 4, 9, 127, 0);
    kick(2);
    repeat (40) @(negedge clk);
    mem[1][31] = 1'b1;
    wait_done(k);
    check(!tmo && maxf == 9 && sumf == 13, "R2 late completion results", sumf, 13);
    check(rlog_a[(rbase + 3) % 1024] == 6'd1 && rlog_a[(rbase + 4) % 1024] == 6'd0,
          "R2 poll until flag", rlog_a[(rbase + 4) % 1024], 0);

    // R10
    fill(63, 62, 0, 127, 1);
    kick(63);
    repeat (20) @(negedge clk);
    start = 1; nsect = 6'd1;
    @(negedge clk);
    start = 0;
    wait_done(k);
    repeat (3) @(negedge clk);
    #1;
    check(maxf == 62 && sumf == 1922, "R10 busy start ignored", sumf, 1922);
    check(dcnt - dbase == 1, "R10 single done", dcnt - dbase, 1);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule